// File: doc/BRIEF.md
# Option-Select Configuration Register Bank

This block is the byte-wide configuration store of an add-in bus adapter. The host reaches it through a small synchronous port: a 3-bit register address, separate read and write strobes, a write byte and a registered read byte. Eight registers sit directly on that port. Two of them hold a fixed 16-bit adapter identifier. The rest hold the adapter's configuration, which is decoded continuously onto dedicated outputs: card enable, interrupt level, arbitration level, DMA enable, streaming enable, byte order, wait state and fairness.

Register 6 has two meanings. A mode bit in register 5 chooses between them. With the mode bit clear, register 6 reports whether a bus error has been latched as a pending channel check, and the host acknowledges that error by writing to it. With the mode bit set, register 6 is an 8-bit pointer. Register 7 then becomes a data port that reaches either a 256-byte product-data ROM or four extra sub-data registers. Each read through the port advances the pointer, so a whole ROM can be streamed out with repeated reads of one address.

The ROM contents are generated from the address by the formula given in R9.

Top module: `optsel_regbank`

## Requirements
- R1: After reset every configuration output is 0, the read byte is 0x00, the pointer is 0, no error is pending, and register 6 is in status mode.
- R2: Registers 0 and 1 read the low byte (0x3C) and the high byte (0x5A) of the adapter ID 0x5A3C. Writes to them change nothing.
- R3: Register 2 holds the following fields: card enable in bit 0, interrupt level in bits 3:1, byte order in bit 4 and wait state in bit 5. The outputs follow from the edge after the write. Bits 7:6 read as 0.
- R4: Register 3 holds the following fields: arbitration level in bits 3:0, fairness in bit 4, DMA enable in bit 5 and streaming enable in bit 6. Bit 7 reads as 0.
- R5: Registers 4 and 5 are full 8-bit read/write registers. Register 5 bit 6 is the mode bit (1 = sub-address mode) and bit 0 selects the port space (0 = ROM, 1 = sub-data registers).
- R6: An input bus error sets the pending channel-check flag. While it is in status mode, register 6 reads 0x80 with the flag set and 0x00 with it clear.
- R7: The pending flag stays set until a status-mode write to register 6 with bit 7 at 0. A write with bit 7 at 1 leaves the flag set, and a bus error in the same cycle as a clearing write keeps it set.
- R8: In sub-address mode, register 6 reads and writes the 8-bit pointer, and such writes leave the pending flag alone. A status-mode write to register 6 leaves the pointer unchanged.
- R9: In sub-address mode with ROM space selected, a read of register 7 returns ROM byte k = (37*k + 11) mod 256 at pointer k. The pointer then increments and wraps from 255 to 0.
- R10: In sub-address mode with sub-data space selected, a read of register 7 returns sub-register pointer[1:0] and then increments the pointer. A write of register 7 stores into that sub-register without moving the pointer. Writes of register 7 while ROM space is selected are ignored.
- R11: In status mode, register 7 reads 0x00. Writes to it, and reads of it, change neither the pointer nor the sub-registers.
- R12: The read byte loads on the clock edge that samples the read strobe, and holds its value while the strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 3 | Register address |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write byte |
| rdata | output | 8 | Registered read byte |
| bus_err | input | 1 | Bus error report, sets pending channel check |
| card_en | output | 1 | Card enable |
| irq_level | output | 3 | Interrupt level |
| byte_order | output | 1 | Byte order select |
| wait_state | output | 1 | Wait state select |
| arb_level | output | 4 | Arbitration level |
| fairness | output | 1 | Fairness enable |
| dma_en | output | 1 | DMA enable |
| stream_en | output | 1 | Streaming enable |

## Verification
The assertions assume that the host never raises the read and write strobes in the same cycle. Under that assumption, each cycle is either a read, whose result depends only on the state before the edge, or a write. The assertions also take the address and strobes to be stable across each clock edge. The bench meets both assumptions by driving every input on the falling edge, one operation per cycle. This holds for its random phase too, which picks exactly one of idle, read or write. Bus errors may arrive in any cycle, including one that carries a clearing write.

// File: rtl/optsel_pkg.sv
package optsel_pkg;

  typedef enum logic [2:0] {
    RA_ID_LO  = 3'd0,
    RA_ID_HI  = 3'd1,
    RA_CFG_A  = 3'd2,
    RA_CFG_B  = 3'd3,
    RA_MEMWIN = 3'd4,
    RA_CTRL   = 3'd5,
    RA_CCSA   = 3'd6,
    RA_PORT   = 3'd7
  } reg_addr_e;

  // Field positions in the control register
  localparam int CTRL_MODE_BIT  = 6;
  localparam int CTRL_SPACE_BIT = 0;
  localparam int STAT_PEND_BIT  = 7;

  // Product-data ROM: generated byte per address
  function automatic logic [7:0] rom_byte(input logic [7:0] a);
    logic [7:0] v;
    v = (a * 8'd37) + 8'd11;
    return v;
  endfunction

endpackage

// File: rtl/optsel_cfg_regs.sv
module optsel_cfg_regs #(
  parameter int DW     = 8,
  parameter int CFGA_W = 6,
  parameter int CFGB_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_cfg_a,
  input  logic              we_cfg_b,
  input  logic              we_memwin,
  input  logic              we_ctrl,
  input  logic [DW-1:0]     wdata,
  output logic [CFGA_W-1:0] cfg_a_q,
  output logic [CFGB_W-1:0] cfg_b_q,
  output logic [DW-1:0]     memwin_q,
  output logic [DW-1:0]     ctrl_q
);

  logic [CFGA_W-1:0] cfg_a_d;
  logic [CFGB_W-1:0] cfg_b_d;
  logic [DW-1:0]     memwin_d;
  logic [DW-1:0]     ctrl_d;

  always_comb begin
    cfg_a_d  = cfg_a_q;
    cfg_b_d  = cfg_b_q;
    memwin_d = memwin_q;
    ctrl_d   = ctrl_q;
    if (we_cfg_a)  cfg_a_d  = wdata[CFGA_W-1:0];
    if (we_cfg_b)  cfg_b_d  = wdata[CFGB_W-1:0];
    if (we_memwin) memwin_d = wdata;
    if (we_ctrl)   ctrl_d   = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_a_q  <= '0;
      cfg_b_q  <= '0;
      memwin_q <= '0;
      ctrl_q   <= '0;
    end else begin
      cfg_a_q  <= cfg_a_d;
      cfg_b_q  <= cfg_b_d;
      memwin_q <= memwin_d;
      ctrl_q   <= ctrl_d;
    end
  end

endmodule

// File: rtl/optsel_ccheck.sv
module optsel_ccheck (
  input  logic clk,
  input  logic rst_n,
  input  logic err_in,
  input  logic ack_clr,
  output logic pend_q
);

  logic pend_d;

  // a fresh error outranks an acknowledge in the same cycle
  always_comb begin
    pend_d = pend_q;
    if (ack_clr) pend_d = 1'b0;
    if (err_in)  pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

endmodule

// File: rtl/optsel_subaddr.sv
module optsel_subaddr #(
  parameter int DW        = 8,
  parameter int ROM_BYTES = 256,
  parameter int N_SUB     = 4,
  localparam int PTR_W    = $clog2(ROM_BYTES),
  localparam int SUB_AW   = $clog2(N_SUB)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ptr_we,
  input  logic [PTR_W-1:0] ptr_wdata,
  input  logic             ptr_adv,
  input  logic             sub_we,
  input  logic [DW-1:0]    sub_wdata,
  input  logic             space_sub,
  output logic [PTR_W-1:0] ptr_q,
  output logic [DW-1:0]    port_data
);

  logic [PTR_W-1:0] ptr_d;
  logic [DW-1:0]    sub_q [N_SUB];
  logic [SUB_AW-1:0] sub_idx;

  assign sub_idx = ptr_q[SUB_AW-1:0];

  always_comb begin
    ptr_d = ptr_q;
    if (ptr_we)       ptr_d = ptr_wdata;
    else if (ptr_adv) ptr_d = ptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  for (genvar g = 0; g < N_SUB; g++) begin : g_sub
    logic          hit;
    logic [DW-1:0] nxt;
    assign hit = sub_we && (sub_idx == SUB_AW'(g));
    always_comb begin
      nxt = sub_q[g];
      if (hit) nxt = sub_wdata;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sub_q[g] <= '0;
      else        sub_q[g] <= nxt;
    end
  end

  always_comb begin
    if (space_sub) port_data = sub_q[sub_idx];
    else           port_data = DW'(optsel_pkg::rom_byte(ptr_q));
  end

endmodule

// File: rtl/optsel_regbank.sv
module optsel_regbank #(
  parameter int          DW        = 8,
  parameter logic [15:0] ADAPTER_ID = 16'h5A3C,
  parameter int          ROM_BYTES = 256,
  parameter int          N_SUB     = 4,
  parameter int          IRQ_W     = 3,
  parameter int          ARB_W     = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       addr,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata,
  input  logic             bus_err,
  output logic             card_en,
  output logic [IRQ_W-1:0] irq_level,
  output logic             byte_order,
  output logic             wait_state,
  output logic [ARB_W-1:0] arb_level,
  output logic             fairness,
  output logic             dma_en,
  output logic             stream_en
);
  import optsel_pkg::*;

  localparam int CFGA_W = 1 + IRQ_W + 2;
  localparam int CFGB_W = ARB_W + 3;
  localparam int PTR_W  = $clog2(ROM_BYTES);

  reg_addr_e sel;
  assign sel = reg_addr_e'(addr);

  logic [CFGA_W-1:0] cfg_a;
  logic [CFGB_W-1:0] cfg_b;
  logic [DW-1:0]     memwin;
  logic [DW-1:0]     ctrl;
  logic              sub_mode;
  logic              space_sub;
  logic              chk_pend;
  logic [PTR_W-1:0]  sub_ptr;
  logic [DW-1:0]     port_data;

  assign sub_mode  = ctrl[CTRL_MODE_BIT];
  assign space_sub = ctrl[CTRL_SPACE_BIT];

  // write decode
  logic we_cfg_a, we_cfg_b, we_memwin, we_ctrl, we_ccsa, we_port, rd_port;
  assign we_cfg_a  = wr_en && (sel == RA_CFG_A);
  assign we_cfg_b  = wr_en && (sel == RA_CFG_B);
  assign we_memwin = wr_en && (sel == RA_MEMWIN);
  assign we_ctrl   = wr_en && (sel == RA_CTRL);
  assign we_ccsa   = wr_en && (sel == RA_CCSA);
  assign we_port   = wr_en && (sel == RA_PORT);
  assign rd_port   = rd_en && (sel == RA_PORT);

  optsel_cfg_regs #(.DW(DW), .CFGA_W(CFGA_W), .CFGB_W(CFGB_W)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .we_cfg_a  (we_cfg_a),
    .we_cfg_b  (we_cfg_b),
    .we_memwin (we_memwin),
    .we_ctrl   (we_ctrl),
    .wdata     (wdata),
    .cfg_a_q   (cfg_a),
    .cfg_b_q   (cfg_b),
    .memwin_q  (memwin),
    .ctrl_q    (ctrl)
  );

  logic ack_clr;
  assign ack_clr = we_ccsa && !sub_mode && !wdata[STAT_PEND_BIT];

  optsel_ccheck u_ccheck (
    .clk     (clk),
    .rst_n   (rst_n),
    .err_in  (bus_err),
    .ack_clr (ack_clr),
    .pend_q  (chk_pend)
  );

  optsel_subaddr #(.DW(DW), .ROM_BYTES(ROM_BYTES), .N_SUB(N_SUB)) u_sub (
    .clk       (clk),
    .rst_n     (rst_n),
    .ptr_we    (we_ccsa && sub_mode),
    .ptr_wdata (wdata[PTR_W-1:0]),
    .ptr_adv   (rd_port && sub_mode),
    .sub_we    (we_port && sub_mode && space_sub),
    .sub_wdata (wdata),
    .space_sub (space_sub),
    .ptr_q     (sub_ptr),
    .port_data (port_data)
  );

  // read path
  logic [DW-1:0] rd_nxt;
  logic [DW-1:0] rdata_q;
  logic [DW-1:0] stat_byte;

  always_comb begin
    stat_byte = '0;
    stat_byte[STAT_PEND_BIT] = chk_pend;
  end

  always_comb begin
    unique case (sel)
      RA_ID_LO:  rd_nxt = DW'(ADAPTER_ID[7:0]);
      RA_ID_HI:  rd_nxt = DW'(ADAPTER_ID[15:8]);
      RA_CFG_A:  rd_nxt = DW'(cfg_a);
      RA_CFG_B:  rd_nxt = DW'(cfg_b);
      RA_MEMWIN: rd_nxt = memwin;
      RA_CTRL:   rd_nxt = ctrl;
      RA_CCSA:   rd_nxt = sub_mode ? DW'(sub_ptr) : stat_byte;
      RA_PORT:   rd_nxt = sub_mode ? port_data : '0;
      default:   rd_nxt = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata_q <= '0;
    else if (rd_en) rdata_q <= rd_nxt;
  end

  assign rdata = rdata_q;

  // decoded configuration fields
  assign card_en    = cfg_a[0];
  assign irq_level  = cfg_a[IRQ_W:1];
  assign byte_order = cfg_a[IRQ_W+1];
  assign wait_state = cfg_a[IRQ_W+2];
  assign arb_level  = cfg_b[ARB_W-1:0];
  assign fairness   = cfg_b[ARB_W];
  assign dma_en     = cfg_b[ARB_W+1];
  assign stream_en  = cfg_b[ARB_W+2];

endmodule

// File: rtl/optsel_regbank_chk.sv
module optsel_regbank_chk #(
  parameter logic [15:0] ADAPTER_ID = 16'h5A3C
) (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] addr,
  input logic       wr_en,
  input logic       rd_en,
  input logic       wbit7,
  input logic [7:0] rdata,
  input logic       bus_err,
  input logic       pend,
  input logic       sub_mode,
  input logic [7:0] ptr
);

  // R2
  id_lo_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 3'd0) |=> rdata == ADAPTER_ID[7:0]);

  // R2
  id_hi_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 3'd1) |=> rdata == ADAPTER_ID[15:8]);

  // R6
  err_sets_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |=> pend);

  // R7
  pend_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !(wr_en && addr == 3'd6 && !sub_mode && !wbit7)) |=> pend);

  // R9
  ptr_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en && addr == 3'd7 && sub_mode) |=> ptr == $past(ptr) + 8'd1);

  // R11
  status_port_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 3'd7 && !sub_mode) |=> rdata == 8'h00);

  // R11
  status_port_ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sub_mode && !(wr_en && addr == 3'd5)) |=> $stable(ptr));

  // R12
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));

  // R12
  no_dual_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && wr_en));

endmodule

bind optsel_regbank optsel_regbank_chk #(.ADAPTER_ID(ADAPTER_ID)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .addr     (addr),
  .wr_en    (wr_en),
  .rd_en    (rd_en),
  .wbit7    (wdata[7]),
  .rdata    (rdata),
  .bus_err  (bus_err),
  .pend     (chk_pend),
  .sub_mode (sub_mode),
  .ptr      (sub_ptr)
);

// File: tb/optsel_regbank_tb_top.sv
`timescale 1ns/1ps
module optsel_regbank_tb_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] addr;
  logic       wr_en, rd_en, bus_err;
  logic [7:0] wdata;
  logic [7:0] rdata;
  logic       card_en, byte_order, wait_state, fairness, dma_en, stream_en;
  logic [2:0] irq_level;
  logic [3:0] arb_level;

  always #10 clk = ~clk;

  optsel_regbank dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .bus_err(bus_err), .card_en(card_en),
    .irq_level(irq_level), .byte_order(byte_order), .wait_state(wait_state),
    .arb_level(arb_level), .fairness(fairness), .dma_en(dma_en),
    .stream_en(stream_en)
  );

  int n_checks = 0;
  int n_fail   = 0;
  string tag = "R1";

  // behavioural reference state
  int m_cfga, m_cfgb, m_mem, m_ctrl, m_ptr, m_rdata;
  bit m_pend;
  int m_sub[4];

  function automatic int rom_ref(int k);
    return (37 * k + 11) % 256;
  endfunction

  function automatic int model_read(int a);
    bit sm = m_ctrl[6];
    case (a)
      0: return 8'h3C;
      1: return 8'h5A;
      2: return m_cfga;
      3: return m_cfgb;
      4: return m_mem;
      5: return m_ctrl;
      6: return sm ? m_ptr : (m_pend ? 8'h80 : 8'h00);
      default: begin
        if (!sm) return 0;
        if (m_ctrl[0]) return m_sub[m_ptr % 4];
        return rom_ref(m_ptr);
      end
    endcase
  endfunction

  task automatic model_step();
    bit sm;
    if (!rst_n) begin
      m_cfga = 0; m_cfgb = 0; m_mem = 0; m_ctrl = 0; m_ptr = 0;
      m_rdata = 0; m_pend = 0;
      for (int i = 0; i < 4; i++) m_sub[i] = 0;
      return;
    end
    sm = m_ctrl[6];
    if (rd_en) begin
      m_rdata = model_read(addr);
      if (addr == 7 && sm) m_ptr = (m_ptr + 1) % 256;
    end
    if (wr_en) begin
      case (addr)
        2: m_cfga = wdata & 8'h3F;
        3: m_cfgb = wdata & 8'h7F;
        4: m_mem  = wdata;
        5: m_ctrl = wdata;
        6: if (sm) m_ptr = wdata; else if (!wdata[7]) m_pend = 0;
        7: if (sm && m_ctrl[0]) m_sub[m_ptr % 4] = wdata;
        default: ;
      endcase
    end
    if (bus_err) m_pend = 1;
  endtask

  task automatic chk(string t, int got, int exp, string what);
    n_checks++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s %s got %02h expected %02h", t, what, got, exp);
    end
  endtask

  task automatic compare();
    chk(tag, rdata, m_rdata, "rdata");
    chk("R3", {2'b0, wait_state, byte_order, irq_level, card_en}, m_cfga, "cfg_a fields");
    chk("R4", {1'b0, stream_en, dma_en, fairness, arb_level}, m_cfgb, "cfg_b fields");
  endtask

  task automatic cyc();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare();
    rd_en = 0; wr_en = 0; bus_err = 0;
  endtask

  task automatic wr(int a, int d, string t);
    tag = t; addr = 3'(a); wdata = 8'(d); wr_en = 1; cyc();
  endtask

  task automatic rd(int a, string t);
    tag = t; addr = 3'(a); rd_en = 1; cyc();
  endtask

  task automatic rd_exp(int a, int e, string t);
    rd(a, t);
    chk(t, rdata, e, "direct expected");
  endtask

  bit done = 0;
  initial begin
    #(20 * 20000);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    addr = 0; wdata = 0; wr_en = 0; rd_en = 0; bus_err = 0; rst_n = 0;
    tag = "R1";
    cyc(); cyc();
    rst_n = 1;
    cyc();
    chk("R1", {card_en, irq_level, arb_level, dma_en, stream_en}, 0, "reset outputs");
    rd_exp(6, 8'h00, "R1");
    // R2 identity
    rd_exp(0, 8'h3C, "R2");
    rd_exp(1, 8'h5A, "R2");
    wr(0, 8'hFF, "R2"); wr(1, 8'h00, "R2");
    rd_exp(0, 8'h3C, "R2");
    rd_exp(1, 8'h5A, "R2");
    // R3 / R4 / R5 fields
    wr(2, 8'hFF, "R3"); rd_exp(2, 8'h3F, "R3");
    wr(2, 8'h0B, "R3"); chk("R3", irq_level, 5, "irq_level");
    wr(3, 8'hFF, "R4"); rd_exp(3, 8'h7F, "R4");
    wr(3, 8'h29, "R4"); chk("R4", arb_level, 9, "arb_level");
    wr(4, 8'hA7, "R5"); rd_exp(4, 8'hA7, "R5");
    wr(5, 8'h3E, "R5"); rd_exp(5, 8'h3E, "R5");
    wr(5, 8'h00, "R5");
    // R6 / R7 channel check
    tag = "R6"; bus_err = 1; cyc();
    rd_exp(6, 8'h80, "R6");
    wr(6, 8'h80, "R7"); rd_exp(6, 8'h80, "R7");
    wr(6, 8'h00, "R7"); rd_exp(6, 8'h00, "R7");
    tag = "R7"; bus_err = 1; addr = 6; wdata = 0; wr_en = 1; cyc();
    rd_exp(6, 8'h80, "R7");
    // R11 status-mode port
    wr(7, 8'h55, "R11"); rd_exp(7, 8'h00, "R11");
    // R8 / R9 ROM streaming with wrap
    wr(5, 8'h40, "R8");
    wr(6, 8'hFE, "R8"); rd_exp(6, 8'hFE, "R8");
    rd_exp(7, rom_ref(254), "R9");
    rd_exp(7, rom_ref(255), "R9");
    rd_exp(7, rom_ref(0), "R9");
    rd_exp(6, 8'h01, "R9");
    wr(7, 8'h99, "R10"); rd_exp(7, rom_ref(1), "R10");
    // R10 sub-data registers
    wr(5, 8'h41, "R10");
    for (int i = 0; i < 4; i++) begin
      wr(6, i, "R10"); wr(7, 8'h10 + i * 17, "R10");
    end
    wr(6, 0, "R10");
    for (int i = 0; i < 4; i++) rd_exp(7, 8'h10 + i * 17, "R10");
    rd_exp(7, 8'h10, "R10");
    // R8 pending survives sub-mode, pointer survives status writes
    rd_exp(6, 8'h05, "R8");
    wr(5, 8'h00, "R8"); rd_exp(6, 8'h80, "R8");
    wr(6, 8'h00, "R8"); rd_exp(6, 8'h00, "R8");
    wr(5, 8'h40, "R8"); rd_exp(6, 8'h05, "R8");
    // R12 hold
    tag = "R12"; cyc(); cyc();
    chk("R12", rdata, 8'h05, "rdata hold");
    // random mix
    for (int n = 0; n < 600; n++) begin
      int op = $urandom_range(0, 2);
      addr = 3'($urandom_range(0, 7));
      wdata = 8'($urandom);
      if ($urandom_range(0, 9) == 0) addr = 3'd5;
      bus_err = ($urandom_range(0, 15) == 0);
      tag = "R12";
      if (op == 1) rd_en = 1;
      else if (op == 2) wr_en = 1;
      cyc();
    end
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule